// File: doc/BRIEF.md
# Dual-Bank Switch Select Register

This block holds the digital control state of a pair of 16-way switch banks, A and B. A control word is presented on a parallel bus and captured on a load strobe. The word carries a 4-bit channel address, an active-low global enable and an active-low select for each bank. Each bank keeps its own 4-bit channel register. From these registers and the captured enable state, the block drives two 16-bit switch-on vectors. Each vector has at most one bit set.

The enable acts on both banks at once and takes priority over everything else. While it is inactive, every switch is open. The bank registers do not depend on the enable. They load only through their own selects, so the stored channels come back when the enable returns. To put the two banks on different channels, software writes twice, each time with only one bank select asserted.

Top module: `dual_bank_sel`

## Requirements
- R1: After reset both bank registers hold channel 0 and the enable state is inactive, so `sw_a` and `sw_b` are all zero until the first captured word with the enable bit at 0.
- R2: The control word has the address in bits [6:3], the active-low enable in bit 2, the bank A select in bit 1 and the bank B select in bit 0. A captured word with bits 2, 1 and 0 all 0 and address n sets only bit n of both outputs, which is switch n+1.
- R3: After a captured word with bit 2 at 1, both outputs are zero, whatever the selects and the register contents are.
- R4: A bank register loads the address only when that bank's select bit is 0 in the captured word. Otherwise it keeps its value.
- R5: A captured word with bit 2 at 1 and a bank select at 0 still loads that bank's register. The new channel appears once a later word sets bit 2 to 0.
- R6: A captured word with bit 2 at 0 and both selects at 1 restores the outputs to the stored channels, not to the address in that word.
- R7: Two writes, each with only one bank select at 0, leave the banks on different channels at the same time.
- R8: Each output is one-hot or zero. The outputs change only on the clock edge that captures a word, and the word bus is ignored while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load strobe; the word is captured on a rising edge while this is high |
| word | input | 7 | Control word: address [6:3], enable_n [2], sel_a_n [1], sel_b_n [0] |
| sw_a | output | 16 | Bank A switch-on vector, bit n closes switch n+1 |
| sw_b | output | 16 | Bank B switch-on vector, bit n closes switch n+1 |

## Verification
Writes with the enable and both selects low, at a middle address and at both end addresses, show that the address is decoded onto the right bit of both banks. Writes with the enable high and different select settings show that the enable override is separate from register loading. A later write with both selects high reveals what each bank stored. Writes with single-bank selects show that each bank loads on its own. Toggling the word with the strobe low shows that the outputs hold between writes.

// File: rtl/dual_bank_sel.sv
module dual_bank_sel #(
  parameter int ADDR_W = 4,
  localparam int CH = 1 << ADDR_W,
  localparam int WW = ADDR_W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [WW-1:0] word,
  output logic [CH-1:0] sw_a,
  output logic [CH-1:0] sw_b
);

  logic [ADDR_W-1:0] addr_a, addr_b;
  logic              en_q;

  wire [ADDR_W-1:0] w_addr  = word[WW-1:3];
  wire              w_en_n  = word[2];
  wire              w_sa_n  = word[1];
  wire              w_sb_n  = word[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a <= '0;
      addr_b <= '0;
      en_q   <= 1'b0;
    end else if (ld) begin
      en_q <= ~w_en_n;
      if (!w_sa_n) addr_a <= w_addr;
      if (!w_sb_n) addr_b <= w_addr;
    end
  end

  localparam logic [CH-1:0] ONE = {{(CH-1){1'b0}}, 1'b1};

  assign sw_a = en_q ? (ONE << addr_a) : '0;
  assign sw_b = en_q ? (ONE << addr_b) : '0;

endmodule

module dual_bank_sel_chk #(
  parameter int ADDR_W = 4,
  localparam int CH = 1 << ADDR_W,
  localparam int WW = ADDR_W + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld,
  input logic [WW-1:0]     word,
  input logic [CH-1:0]     sw_a,
  input logic [CH-1:0]     sw_b,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b
);

  localparam logic [CH-1:0] ONE = {{(CH-1){1'b0}}, 1'b1};

  // R8
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_a) && $onehot0(sw_b));

  // R3
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld && word[2] |=> sw_a == '0 && sw_b == '0);

  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld && word[1] |=> $stable(addr_a));

  // R4
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld && word[0] |=> $stable(addr_b));

  // R2
  decode_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld && word[2:1] == 2'b00 |=> sw_a == (ONE << $past(word[WW-1:3])));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(sw_a) && $stable(sw_b));

endmodule

bind dual_bank_sel dual_bank_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .word(word),
  .sw_a(sw_a), .sw_b(sw_b), .addr_a(addr_a), .addr_b(addr_b)
);

// File: tb/tb_dual_bank_sel.sv
module tb_dual_bank_sel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ld = 0;
  logic [6:0]  word = '0;
  logic [15:0] sw_a, sw_b;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [3:0] ma = 0, mb = 0;
  bit         men = 0;

  always #10 clk = ~clk;

  dual_bank_sel dut (.clk(clk), .rst_n(rst_n), .ld(ld), .word(word), .sw_a(sw_a), .sw_b(sw_b));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, bit en_n, bit sa_n, bit sb_n, string tag);
    logic [15:0] ea, eb;
    men = !en_n;
    if (!sa_n) ma = a;
    if (!sb_n) mb = a;
    ea = men ? (16'h1 << ma) : 16'h0;
    eb = men ? (16'h1 << mb) : 16'h0;
    @(negedge clk);
    word = {a, en_n, sa_n, sb_n};
    ld = 1;
    exp_q.push_back({ea, eb});
    tag_q.push_back(tag);
    @(negedge clk);
    ld = 0;
  endtask

  // monitor: a write captured at a rising edge is compared at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (ld && rst_n) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), {sw_a, sw_b}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {sw_a, sw_b}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {sw_a, sw_b}, 32'h0);

    wr(4'b0100, 0, 0, 0, "R2 address 4 both banks");
    wr(4'b0010, 1, 1, 1, "R3 enable high all off");
    wr(4'b1000, 0, 1, 1, "R6 restore stored channels");
    wr(4'b1000, 0, 0, 1, "R7 R4 bank A only");
    wr(4'b0001, 0, 1, 0, "R7 banks differ");
    wr(4'b1111, 1, 0, 0, "R3 R5 load while off");
    wr(4'b0000, 0, 1, 1, "R5 loaded channel appears");
    wr(4'b0000, 0, 0, 0, "R2 address 0");
    wr(4'b1111, 0, 0, 0, "R2 address 15");

    @(negedge clk);
    word = 7'b0011_000;
    repeat (4) @(negedge clk);
    check("R8 ignored while strobe low", {sw_a, sw_b}, {16'h8000, 16'h8000});
    word = 7'b0000_100;
    @(negedge clk);
    check("R8 still held", {sw_a, sw_b}, {16'h8000, 16'h8000});
    repeat (2) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule